// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned integers over many clock cycles using a single adder that is only as wide as one operand. A one-cycle start request, accepted only while the block is idle, captures the multiplicand into a holding register. The same request places the multiplier in the lower half of a double-width product register and clears the upper half. The multiplier has no register of its own. Its bits are consumed from the low end of the product register as the product shifts right.

On each of the following clock cycles the block examines bit 0 of the product register. When that bit is set, it adds the multiplicand into the upper half and keeps the adder's carry-out. It then shifts the carry, the upper half and the lower half right by one position. After one iteration per multiplier bit, a one-cycle completion flag is raised. The full-width product then holds its value until the next accepted start. A surrounding controller uses it by pulsing start with both operands and then waiting for the completion flag.

Top module: `seqmul`

## Requirements
- R1: While reset is asserted (active-low `rst_n` = 0) and in the first cycle after it is released, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: A start request (`start_i` = 1) seen at a clock edge while `busy_o` = 0 makes `busy_o` = 1 after that edge, with `product_o` equal to the multiplier in bits [31:0] and zeros in bits [63:32].
- R3: After the loading edge, exactly 32 further clock edges perform one iteration each. `done_o` rises after the 32nd of them.
- R4: When `done_o` = 1, `product_o` equals the full 64-bit unsigned product of the captured multiplicand and multiplier.
- R5: `done_o` is high for exactly one cycle. `busy_o` falls at the same edge where `done_o` rises, and the two are never high together.
- R6: A start request while `busy_o` = 1 is ignored: the operation in progress finishes on schedule with the operands it captured, and new operand values have no effect on its result.
- R7: While `busy_o` = 0 and no start request is present, `product_o` does not change.
- R8: The carry-out of the upper-half addition is kept and shifted into bit 63, so an all-ones by all-ones product (0xFFFFFFFE00000001) is exact.
- R9: In an iteration where product bit 0 is 0, the whole product register shifts right by one with a zero entering bit 63. In every iteration, the lower bits [30:0] take the old bits [31:1].
- R10: Small operands give exact results, for example multiplicand 2 (binary 0010) times multiplier 11 (binary 1011) gives 22 (binary 0010110).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| mcand_i | input | 32 | Multiplicand operand |
| mplier_i | input | 32 | Multiplier operand |
| busy_o | output | 1 | High while iterations are in progress |
| done_o | output | 1 | One-cycle completion flag |
| product_o | output | 64 | Product register contents |

## Verification
The bench targets operands that exercise the carry path. All-ones times all-ones would lose its top bit in a design that dropped the adder carry. Zero operands and single-bit multipliers would show a wrong iteration count or an off-by-one in the shift. A second start request is injected in the middle of a run with different operands. A design that accepted it would either return a mixed product or stretch the operation, and the cycle count and the product check would catch both. The bench also checks that the product holds after completion, and it reproduces the small four-bit example exactly.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;

  // Control state of the iteration sequencer
  typedef enum logic [0:0] {
    CTL_IDLE = 1'b0,
    CTL_RUN  = 1'b1
  } ctl_state_e;

  // Adder implementation choice
  typedef enum logic [0:0] {
    ADD_BEHAV  = 1'b0,
    ADD_RIPPLE = 1'b1
  } add_style_e;

endpackage

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl
  import seqmul_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic load_en_o,
  output logic step_en_o
);

  localparam int unsigned CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST_ITER = CW'(WIDTH - 1);

  ctl_state_e      state_q;
  logic [CW-1:0]   iter_q;
  logic            last_step;

  assign busy_o    = (state_q == CTL_RUN);
  assign load_en_o = start_i && (state_q == CTL_IDLE);
  assign step_en_o = (state_q == CTL_RUN);
  assign last_step = step_en_o && (iter_q == LAST_ITER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CTL_IDLE;
      iter_q  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= last_step;
      if (load_en_o) begin
        state_q <= CTL_RUN;
        iter_q  <= '0;
      end else if (last_step) begin
        state_q <= CTL_IDLE;
        iter_q  <= '0;
      end else if (step_en_o) begin
        iter_q  <= iter_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/seqmul_adder.sv
module seqmul_adder
  import seqmul_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter add_style_e  STYLE = ADD_BEHAV
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);

  generate
    if (STYLE == ADD_RIPPLE) begin : g_ripple
      logic [WIDTH:0] chain;
      assign chain[0] = 1'b0;
      for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        assign sum_o[gi]     = a_i[gi] ^ b_i[gi] ^ chain[gi];
        assign chain[gi + 1] = (a_i[gi] & b_i[gi]) | (chain[gi] & (a_i[gi] ^ b_i[gi]));
      end
      assign carry_o = chain[WIDTH];
    end else begin : g_behav
      logic [WIDTH:0] wide_sum;
      assign wide_sum = {1'b0, a_i} + {1'b0, b_i};
      assign sum_o    = wide_sum[WIDTH-1:0];
      assign carry_o  = wide_sum[WIDTH];
    end
  endgenerate

endmodule

// File: rtl/seqmul_preg.sv
module seqmul_preg #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned PW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en_i,
  input  logic             step_en_i,
  input  logic [WIDTH-1:0] mplier_i,
  input  logic [WIDTH-1:0] sum_i,
  input  logic             carry_i,
  output logic [PW-1:0]    prod_o
);

  // Shift {carry, sum, low half} right by one: carry lands in the top bit
  function automatic logic [PW-1:0] shift_in(input logic c,
                                             input logic [WIDTH-1:0] hi,
                                             input logic [WIDTH-1:0] lo);
    logic [PW:0] joined;
    joined   = {c, hi, lo};
    shift_in = joined[PW:1];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_o <= '0;
    end else if (load_en_i) begin
      prod_o <= {{WIDTH{1'b0}}, mplier_i};
    end else if (step_en_i) begin
      prod_o <= shift_in(carry_i, sum_i, prod_o[WIDTH-1:0]);
    end
  end

endmodule

// File: rtl/seqmul.sv
module seqmul
  import seqmul_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter add_style_e  ADD_STYLE = ADD_BEHAV,
  localparam int unsigned PW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [PW-1:0]    product_o
);

  logic             load_en;
  logic             step_en;
  logic             add_en;
  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] sum;
  logic             carry;

  seqmul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .load_en_o (load_en),
    .step_en_o (step_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
    end else if (load_en) begin
      mcand_q <= mcand_i;
    end
  end

  assign add_en = step_en && product_o[0];
  assign addend = add_en ? mcand_q : '0;

  seqmul_adder #(.WIDTH(WIDTH), .STYLE(ADD_STYLE)) u_add (
    .a_i     (product_o[PW-1:WIDTH]),
    .b_i     (addend),
    .sum_o   (sum),
    .carry_o (carry)
  );

  seqmul_preg #(.WIDTH(WIDTH)) u_preg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en_i (load_en),
    .step_en_i (step_en),
    .mplier_i  (mplier_i),
    .sum_i     (sum),
    .carry_i   (carry),
    .prod_o    (product_o)
  );

endmodule

// File: rtl/seqmul_chk.sv
module seqmul_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic [WIDTH-1:0]   mplier_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [2*WIDTH-1:0] product_o,
  input logic               step_en
);

  localparam int unsigned CW = $clog2(WIDTH + 2);

  // Cycles elapsed since the last accepted start
  logic [CW-1:0] since_load;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_load <= '0;
    else if (start_i && !busy_o) since_load <= '0;
    else if (busy_o) since_load <= since_load + 1'b1;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && product_o == {{WIDTH{1'b0}}, $past(mplier_i)}));

  p_iter_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (since_load == CW'(WIDTH)));

  p_busy_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (since_load < CW'(WIDTH)));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && since_load < CW'(WIDTH - 1)) |=> busy_o);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(product_o));

  p_plain_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !product_o[0]) |=> (product_o == ($past(product_o) >> 1)));

  p_low_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (product_o[WIDTH-2:0] == $past(product_o[WIDTH-1:1])));

endmodule

bind seqmul seqmul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .mplier_i  (mplier_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .product_o (product_o),
  .step_en   (step_en)
);

// File: tb/seqmul_tb.sv
module seqmul_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] mcand_i = '0;
  logic [31:0] mplier_i = '0;
  logic        busy_o;
  logic        done_o;
  logic [63:0] product_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  seqmul u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
  );

  function automatic logic [63:0] ref_product(input logic [31:0] a, input logic [31:0] b);
    longint unsigned wa, wb;
    wa = 64'(a);
    wb = 64'(b);
    return wa * wb;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%016h expected 0x%016h", req, got, exp);
    end
  endtask

  // Run one multiplication; optionally inject a second start mid-run
  task automatic run_mul(input logic [31:0] a, input logic [31:0] b, input bit inject, input string tag);
    int cycles;
    logic [63:0] held;
    @(negedge clk);
    start_i = 1'b1; mcand_i = a; mplier_i = b;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1 && product_o === {32'h0, b}, {"R2 load ", tag}, product_o, {32'h0, b});
    cycles = 0;
    while (done_o !== 1'b1 && cycles < 40) begin
      if (inject && cycles == 5) begin
        start_i = 1'b1; mcand_i = ~a; mplier_i = ~b;
      end
      @(negedge clk);
      start_i = 1'b0;
      cycles++;
    end
    check(cycles == 32, {"R3 iteration count ", tag}, 64'(cycles), 64'd32);
    check(product_o === ref_product(a, b), {"R4 product ", tag}, product_o, ref_product(a, b));
    check(busy_o === 1'b0, {"R5 busy low at done ", tag}, 64'(busy_o), 64'd0);
    if (inject)
      check(product_o === ref_product(a, b), {"R6 mid-run start ignored ", tag}, product_o, ref_product(a, b));
    held = product_o;
    @(negedge clk);
    check(done_o === 1'b0, {"R5 done single cycle ", tag}, 64'(done_o), 64'd0);
    check(product_o === held, {"R7 idle hold ", tag}, product_o, held);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0 && product_o === 64'h0, "R1 in reset", product_o, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0 && product_o === 64'h0, "R1 after reset", product_o, 64'h0);

    run_mul(32'd2, 32'd11, 1'b0, "R10 four-bit example");
    check(product_o === 64'd22, "R10 0010 x 1011", product_o, 64'd22);
    run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R8 all ones");
    check(product_o === 64'hFFFF_FFFE_0000_0001, "R8 carry kept", product_o, 64'hFFFF_FFFE_0000_0001);
    run_mul(32'h0, 32'hDEAD_BEEF, 1'b0, "R9 zero multiplicand");
    run_mul(32'hDEAD_BEEF, 32'h0, 1'b0, "R9 zero multiplier");
    run_mul(32'h8000_0000, 32'h8000_0000, 1'b0, "R8 top bits");
    run_mul(32'h1234_5678, 32'h0000_0001, 1'b0, "R9 single low bit");
    run_mul(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b1, "R6 inject");

    for (int k = 0; k < 40; k++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (k % 8 == 3) ra = 32'hFFFF_FFFF;
      run_mul(ra, rb, (k % 5 == 2), "random");
    end

    // Idle hold with operand churn and no start
    begin
      logic [63:0] held;
      held = product_o;
      mcand_i = 32'h1357_9BDF; mplier_i = 32'h2468_ACE0;
      repeat (4) @(negedge clk);
      check(product_o === held && busy_o === 1'b0, "R7 operands change while idle", product_o, held);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule